// File: doc/BRIEF.md
# Shared-Term Carry-Lookahead ALU

This block is a 16-bit arithmetic and logic unit with a registered output. Two operands and a two-bit operation select go in. One clock edge later, the selected result and a zero flag come out. The adder is a full carry-lookahead design. Each bit first forms two terms: the AND of its operand bits, which is the generate term, and their OR, which is the propagate term. Every carry is then a flat sum-of-products over the generate and propagate terms of the bits below it, together with the carry-in. As a result, no carry waits on its neighbour.

The bitwise AND and OR operations reuse those same generate and propagate vectors as their results, so they cost no extra logic in the datapath. Subtraction inverts operand B and sets the carry-in to one. A mode input narrows the zero test to the low byte. This lets software that keeps 8-bit values in 16-bit words branch on the byte alone.

Top module: `shared_term_alu`

## Requirements
- R1: While `rst` is high at a rising clock edge, `res_q` becomes 0 and `zero_q` becomes 1.
- R2: Operation code 2'b00 (add) yields `res_q` = (`opa` + `opb`) mod 2^16.
- R3: Operation code 2'b01 (subtract) yields `res_q` = (`opa` - `opb`) mod 2^16, i.e. `opa` + ~`opb` + 1.
- R4: Operation code 2'b10 yields the bitwise AND of `opa` and `opb`.
- R5: Operation code 2'b11 yields the bitwise OR of `opa` and `opb`.
- R6: With `byte_mode` low, `zero_q` is 1 exactly when all 16 bits of the registered result are 0.
- R7: With `byte_mode` high, `zero_q` is 1 exactly when result bits 7:0 are 0, whatever bits 15:8 hold. The result value itself is unchanged by the mode.
- R8: Outputs reflect the inputs present at the previous rising edge: latency is exactly one cycle.
- R9: A carry generated in bit 0 reaches bit 15 and wraps out of the top within the same cycle (0x7FFF+1 = 0x8000, 0xFFFF+1 = 0x0000).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| opa | input | 16 | Operand A |
| opb | input | 16 | Operand B |
| op_sel | input | 2 | 00 add, 01 subtract, 10 and, 11 or |
| byte_mode | input | 1 | When high, the zero flag tests only bits 7:0 |
| res_q | output | 16 | Registered result |
| zero_q | output | 1 | Registered zero flag |

## Verification
Random operand pairs under each of the four codes separate the arithmetic paths from the logic paths and catch wrong opcode decoding. All-ones and all-zeros operands, together with the 0x7FFF+1 and 0xFFFF+1 sums and 0-1, drive a carry through every position. These cases show whether any single flattened carry term is missing. Results of 0x0100 and 0xFF00+0x0100 are each presented with the mode high and low, which separates a full-width zero test from a low-byte one. Changing the operands on every cycle exposes any extra or missing pipeline stage.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int DATA_W   = 16;
    localparam int NARROW_W = 8;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_AND = 2'b10,
        OP_OR  = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] gen;   // per-bit AND term
        logic [DATA_W-1:0] prop;  // per-bit OR term
        logic              cin;
    } term_t;

    function automatic logic is_arith(alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction
endpackage

// File: rtl/term_stage.sv
module term_stage
    import alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] gen,
    output logic [W-1:0] prop,
    output logic         cin
);
    logic          invert;
    logic [W-1:0]  b_eff;

    assign invert = (op == OP_SUB);
    assign b_eff  = invert ? ~b : b;
    assign gen    = a & b_eff;
    assign prop   = a | b_eff;
    assign cin    = invert;
endmodule

// File: rtl/carry_flat.sv
module carry_flat #(
    parameter int W = 16
) (
    input  logic [W-1:0] gen,
    input  logic [W-1:0] prop,
    input  logic         cin,
    output logic [W-1:0] carry   // carry[i] enters bit i
);
    assign carry[0] = cin;

    for (genvar i = 1; i < W; i++) begin : g_carry
        // carry into bit i: OR over j<i of gen[j] & prop[j+1..i-1], plus cin & prop[0..i-1]
        logic [i:0] prods;
        always_comb begin
            for (int j = 0; j < i; j++) begin
                prods[j] = gen[j];
                for (int m = j + 1; m < i; m++) begin
                    prods[j] = prods[j] & prop[m];
                end
            end
            prods[i] = cin;
            for (int m = 0; m < i; m++) begin
                prods[i] = prods[i] & prop[m];
            end
        end
        assign carry[i] = |prods;
    end
endmodule

// File: rtl/result_select.sv
module result_select
    import alu_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int NW = NARROW_W
) (
    input  alu_op_e      op,
    input  logic [W-1:0] gen,
    input  logic [W-1:0] prop,
    input  logic [W-1:0] carry,
    input  logic         byte_mode,
    output logic [W-1:0] res,
    output logic         zero
);
    logic [W-1:0] half_sum;

    // a xor b recovered from the shared terms: OR but not AND
    assign half_sum = prop & ~gen;

    always_comb begin
        unique case (op)
            OP_AND:  res = gen;
            OP_OR:   res = prop;
            default: res = half_sum ^ carry;
        endcase
    end

    assign zero = byte_mode ? ~|res[NW-1:0] : ~|res;
endmodule

// File: rtl/shared_term_alu.sv
module shared_term_alu
    import alu_pkg::*;
#(
    parameter int WIDTH  = DATA_W,
    parameter int NARROW = NARROW_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic [1:0]       op_sel,
    input  logic             byte_mode,
    output logic [WIDTH-1:0] res_q,
    output logic             zero_q
);
    alu_op_e        op;
    logic [WIDTH-1:0] gen, prop, carry, res_d;
    logic           cin, zero_d;

    assign op = alu_op_e'(op_sel);

    term_stage #(.W(WIDTH)) u_terms (
        .a(opa), .b(opb), .op(op), .gen(gen), .prop(prop), .cin(cin)
    );

    carry_flat #(.W(WIDTH)) u_carry (
        .gen(gen), .prop(prop), .cin(cin), .carry(carry)
    );

    result_select #(.W(WIDTH), .NW(NARROW)) u_sel (
        .op(op), .gen(gen), .prop(prop), .carry(carry),
        .byte_mode(byte_mode), .res(res_d), .zero(zero_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            zero_q <= 1'b1;
        end else begin
            res_q  <= res_d;
            zero_q <= zero_d;
        end
    end
endmodule

// File: rtl/shared_term_alu_chk.sv
module shared_term_alu_chk #(
    parameter int W  = 16,
    parameter int NW = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] opa,
    input logic [W-1:0] opb,
    input logic [1:0]   op_sel,
    input logic         byte_mode,
    input logic [W-1:0] res_q,
    input logic         zero_q
);
    logic rst_seen;

    always @(posedge clk) begin
        rst_seen <= rst;
        if (rst_seen === 1'b1) begin
            a_reset_state_r1: assert (res_q == '0 && zero_q == 1'b1);
        end
    end

    p_add_r2: assert property (@(posedge clk) disable iff (rst)
        op_sel == 2'b00 |=> res_q == W'($past(opa) + $past(opb)));

    p_sub_r3: assert property (@(posedge clk) disable iff (rst)
        op_sel == 2'b01 |=> res_q == W'($past(opa) - $past(opb)));

    p_and_r4: assert property (@(posedge clk) disable iff (rst)
        op_sel == 2'b10 |=> res_q == ($past(opa) & $past(opb)));

    p_or_r5: assert property (@(posedge clk) disable iff (rst)
        op_sel == 2'b11 |=> res_q == ($past(opa) | $past(opb)));

    p_wide_zero_r6: assert property (@(posedge clk) disable iff (rst)
        !byte_mode |=> zero_q == (res_q == '0));

    p_byte_zero_r7: assert property (@(posedge clk) disable iff (rst)
        byte_mode |=> zero_q == (res_q[NW-1:0] == '0));
endmodule

bind shared_term_alu shared_term_alu_chk #(.W(WIDTH), .NW(NARROW)) chk_i (
    .clk(clk), .rst(rst), .opa(opa), .opb(opb), .op_sel(op_sel),
    .byte_mode(byte_mode), .res_q(res_q), .zero_q(zero_q)
);

// File: tb/shared_term_alu_tb_top.sv
module shared_term_alu_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] opa = '0, opb = '0;
    logic [1:0]  op_sel = '0;
    logic        byte_mode = 1'b0;
    logic [15:0] res_q;
    logic        zero_q;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    shared_term_alu dut_i (
        .clk(clk), .rst(rst), .opa(opa), .opb(opb), .op_sel(op_sel),
        .byte_mode(byte_mode), .res_q(res_q), .zero_q(zero_q)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000 && !done) begin
            mismatched = mismatched + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected < 50000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    function automatic logic [15:0] model(logic [15:0] a, logic [15:0] b, logic [1:0] op);
        int ai = a, bi = b, r;
        case (op)
            2'b00: r = (ai + bi) % 65536;
            2'b01: r = (ai - bi + 65536) % 65536;
            2'b10: r = ai & bi;
            default: r = ai | bi;
        endcase
        return 16'(r);
    endfunction

    task automatic check(string req, logic [15:0] exp_r, logic exp_z);
        compared++;
        if (res_q !== exp_r || zero_q !== exp_z) begin
            mismatched++;
            $display("FAIL %s: actual res=%h zero=%b expected res=%h zero=%b",
                     req, res_q, zero_q, exp_r, exp_z);
        end
    endtask

    // drive at a falling edge, compare at the next falling edge (one register in between)
    task automatic step(string req, logic [15:0] a, logic [15:0] b, logic [1:0] op, logic bm);
        logic [15:0] e;
        logic        z;
        opa = a; opb = b; op_sel = op; byte_mode = bm;
        e = model(a, b, op);
        z = bm ? (e[7:0] == 8'h00) : (e == 16'h0000);
        @(negedge clk);
        check(req, e, z);
    endtask

    initial begin
        // R1: reset state, with non-zero inputs present
        opa = 16'h1234; opb = 16'h4321; op_sel = 2'b11;
        repeat (3) @(negedge clk);
        check("R1", 16'h0000, 1'b1);
        rst = 1'b0;

        // R9 / R2: full-width carry ripple and wrap
        step("R9", 16'h7FFF, 16'h0001, 2'b00, 1'b0);
        step("R9", 16'hFFFF, 16'h0001, 2'b00, 1'b0);
        step("R2", 16'hFFFF, 16'hFFFF, 2'b00, 1'b0);
        step("R2", 16'h0000, 16'h0000, 2'b00, 1'b0);
        // R3: borrow through all bits, equal operands
        step("R3", 16'h0000, 16'h0001, 2'b01, 1'b0);
        step("R3", 16'hABCD, 16'hABCD, 2'b01, 1'b0);
        step("R3", 16'h8000, 16'h0001, 2'b01, 1'b0);
        // R4 / R5 corners
        step("R4", 16'hFFFF, 16'h0000, 2'b10, 1'b0);
        step("R4", 16'hFFFF, 16'hFFFF, 2'b10, 1'b0);
        step("R5", 16'h0000, 16'h0000, 2'b11, 1'b0);
        step("R5", 16'hF0F0, 16'h0F0F, 2'b11, 1'b0);
        // R6 / R7: 0x0100 is zero only in byte mode
        step("R6", 16'h00FF, 16'h0001, 2'b00, 1'b0);
        step("R7", 16'h00FF, 16'h0001, 2'b00, 1'b1);
        step("R7", 16'hFF00, 16'h0100, 2'b00, 1'b1);
        step("R6", 16'hFF00, 16'h0100, 2'b00, 1'b0);
        step("R7", 16'h1200, 16'h3400, 2'b11, 1'b1);

        // R8: back-to-back changes, each result from the previous edge only
        for (int i = 0; i < 8; i++) begin
            step("R8", 16'(i * 4099), 16'(i * 257 + 3), 2'(i), 1'(i % 2));
        end

        // random sweep over all codes (R2..R5, R6, R7)
        for (int i = 0; i < 2000; i++) begin
            logic [1:0] op;
            op = 2'($urandom_range(0, 3));
            case (op)
                2'b00: step("R2", 16'($urandom), 16'($urandom), op, 1'($urandom));
                2'b01: step("R3", 16'($urandom), 16'($urandom), op, 1'($urandom));
                2'b10: step("R4", 16'($urandom), 16'($urandom), op, 1'($urandom));
                default: step("R5", 16'($urandom), 16'($urandom), op, 1'($urandom));
            endcase
        end

        // R1: mid-run reset clears again
        rst = 1'b1; opa = 16'h0F0F; opb = 16'h0101; op_sel = 2'b00;
        @(negedge clk);
        check("R1", 16'h0000, 1'b1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule